// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A host writes a character into a one-entry holding buffer. When the transmit enable is set and the line is free, the block moves the character into a shift register and sends it. Each frame is a low start bit, then the data bits with the least-significant bit first, then a parity bit if parity is enabled, and then a high stop period. The line rests high between frames.

The character length, parity, stop-bit length and clock factor are run-time inputs. The block reads them at the moment a frame is loaded. Bit timing counts pulses of an external bit-clock enable, so one bit lasts 1, 16 or 64 enables. A break input pulls the line low and has priority over everything else. Two status outputs tell the host when it can write another character and when the transmitter has gone completely quiet.

Top module: `async_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A `wr_stb` pulse while `tx_rdy` is 1 stores `wr_data`, and `tx_rdy` reads 0 on the next cycle. A `wr_stb` while `tx_rdy` is 0 is ignored, and the stored character is kept.
- R3: A frame is a 0 start bit followed by the data bits, least-significant bit first. The number of data bits is 5, 6, 7 or 8 for `len_code` 00, 01, 10 or 11. Data bits above the selected length are not sent.
- R4: With `par_en`=1, a parity bit follows the data bits. With `par_even`=1 the parity bit makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd. With `par_en`=0 no parity bit is sent.
- R5: Each start, data and parity bit lasts this many `bclk_en` pulses: 16 for `fac_code` 10, 64 for 11, and 1 for 01 or 00.
- R6: The stop period is high and lasts one bit time for `stop_code` 01 or 00, and two bit times for 11. For `stop_code` 10 it lasts 1.5 bit times (24 or 96 enables); at the ×1 factor this rounds up to 2.
- R7: A frame starts only while `tx_en` is 1. Clearing `tx_en` during a frame lets that frame finish unchanged.
- R8: While `brk` is 1, `txd` is 0.
- R9: `tx_empty` is 1 exactly when no character is stored and no frame is in progress. After the last stop cycle of a frame with nothing stored, it reads 1 on the next cycle.
- R10: If a character is stored and `tx_en` is 1 when a stop period ends, its start bit follows on the next cycle with no idle gap.
- R11: While `bclk_en` is 0, the frame timing halts and `txd` holds its current bit.
- R12: Outside a frame and without break, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Holding-buffer write strobe |
| wr_data | input | 8 | Character to send |
| len_code | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_code | input | 2 | Stop length code |
| fac_code | input | 2 | Clock factor code |
| tx_en | input | 1 | Permits new frames to start |
| brk | input | 1 | Forces the line low |
| bclk_en | input | 1 | Bit-clock enable pulse |
| txd | output | 1 | Serial output line |
| tx_rdy | output | 1 | Holding buffer can take a character |
| tx_empty | output | 1 | Buffer empty and no frame in progress |

## Verification
The bench uses the default parameters: an 8-bit maximum character and factors of 16 and 64. For most tests it holds `bclk_en` high, so every bit time is an exact number of clock cycles. This lets the bench compare `txd` cycle by cycle against a frame it builds itself. It sweeps every length, every parity mode, all four stop codes and the ×1 and ×16 factors, then runs frames at ×64 with each stop code. That reaches the rounded 1.5-bit stop, the 96-enable stop and the widest frame. Separate tests cover the holding buffer, the transmit enable, back-to-back frames, break, and a stalled bit clock.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_STOP = 2'd2
    } tx_state_e;

endpackage

// File: rtl/atx_frame_build.sv
// Turns the stored character and the live configuration into a full frame
// image, the number of bit slots to shift, and the two timing limits.
module atx_frame_build #(
    parameter int DATA_W  = 8,
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64,
    parameter int FRAME_W = DATA_W + 2,
    parameter int NB_W    = $clog2(FRAME_W + 1),
    parameter int TIM_W   = $clog2(2 * FAC_HI + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         len_code,
    input  logic               par_en,
    input  logic               par_even,
    input  logic [1:0]         stop_code,
    input  logic [1:0]         fac_code,
    output logic [FRAME_W-1:0] frame,
    output logic [NB_W-1:0]    nbits,
    output logic [TIM_W-1:0]   bit_lim,
    output logic [TIM_W-1:0]   stop_lim
);

    localparam int MIN_LEN = DATA_W - 3;

    logic [NB_W-1:0]    len_n;
    logic [FRAME_W-1:0] dpad;
    logic               par_x;
    logic               par_bit;

    assign len_n = NB_W'(MIN_LEN) + NB_W'(len_code);
    assign dpad  = FRAME_W'(data);

    always_comb begin
        par_x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (NB_W'(i) < len_n) par_x = par_x ^ data[i];
        end
        par_bit = par_even ? par_x : ~par_x;

        frame    = '1;
        frame[0] = 1'b0;
        for (int k = 0; k < FRAME_W - 1; k++) begin
            if (NB_W'(k) < len_n)                frame[k+1] = dpad[k];
            else if (NB_W'(k) == len_n && par_en) frame[k+1] = par_bit;
        end
        nbits = len_n + NB_W'(1) + NB_W'(par_en);
    end

    always_comb begin
        case (fac_code)
            2'b10:   bit_lim = TIM_W'(FAC_MID);
            2'b11:   bit_lim = TIM_W'(FAC_HI);
            default: bit_lim = TIM_W'(1);
        endcase
        case (stop_code)
            2'b10:   stop_lim = (bit_lim == TIM_W'(1)) ? TIM_W'(2)
                                                       : bit_lim + (bit_lim >> 1);
            2'b11:   stop_lim = bit_lim << 1;
            default: stop_lim = bit_lim;
        endcase
    end

endmodule

// File: rtl/atx_bit_timer.sv
// Counts bit-clock enables up to a limit and flags the last one.
module atx_bit_timer #(
    parameter int TIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [TIM_W-1:0] lim,
    output logic             done
);

    typedef struct packed {
        logic [TIM_W-1:0] cnt;
    } tim_t;

    tim_t q, d;

    assign done = en && (q.cnt == lim - TIM_W'(1));

    always_comb begin
        d = q;
        if (clr || done) d.cnt = '0;
        else if (en)     d.cnt = q.cnt + TIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer #(
    parameter int DATA_W  = 8,
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        stop_code,
    input  logic [1:0]        fac_code,
    input  logic              tx_en,
    input  logic              brk,
    input  logic              bclk_en,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);
    import atx_pkg::*;

    localparam int FRAME_W = DATA_W + 2;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int TIM_W   = $clog2(2 * FAC_HI + 1);

    typedef struct packed {
        tx_state_e          st;
        logic               hold_v;
        logic [DATA_W-1:0]  hold_d;
        logic [FRAME_W-1:0] sh;
        logic [NB_W-1:0]    left;
        logic [TIM_W-1:0]   bit_lim;
        logic [TIM_W-1:0]   stop_lim;
    } regs_t;

    regs_t q, d;

    logic [FRAME_W-1:0] fr_img;
    logic [NB_W-1:0]    fr_nbits;
    logic [TIM_W-1:0]   fr_bit_lim;
    logic [TIM_W-1:0]   fr_stop_lim;
    logic [TIM_W-1:0]   tim_lim;
    logic               tick;
    logic               load;
    logic               frame_active;

    atx_frame_build #(
        .DATA_W (DATA_W),
        .FAC_MID(FAC_MID),
        .FAC_HI (FAC_HI),
        .FRAME_W(FRAME_W),
        .NB_W   (NB_W),
        .TIM_W  (TIM_W)
    ) u_build (
        .data     (q.hold_d),
        .len_code (len_code),
        .par_en   (par_en),
        .par_even (par_even),
        .stop_code(stop_code),
        .fac_code (fac_code),
        .frame    (fr_img),
        .nbits    (fr_nbits),
        .bit_lim  (fr_bit_lim),
        .stop_lim (fr_stop_lim)
    );

    assign tim_lim = (q.st == ST_STOP) ? q.stop_lim : q.bit_lim;

    atx_bit_timer #(
        .TIM_W(TIM_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (bclk_en),
        .clr  (q.st == ST_IDLE),
        .lim  (tim_lim),
        .done (tick)
    );

    assign frame_active = (q.st != ST_IDLE);
    assign load = q.hold_v && tx_en &&
                  ((q.st == ST_IDLE) || (q.st == ST_STOP && tick));

    always_comb begin
        d = q;
        if (wr_stb && !q.hold_v) begin
            d.hold_v = 1'b1;
            d.hold_d = wr_data;
        end
        case (q.st)
            ST_DATA: begin
                if (tick) begin
                    d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                    d.left = q.left - NB_W'(1);
                    if (q.left == NB_W'(1)) d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) d.st = ST_IDLE;
            end
            default: ;
        endcase
        if (load) begin
            d.st       = ST_DATA;
            d.sh       = fr_img;
            d.left     = fr_nbits;
            d.bit_lim  = fr_bit_lim;
            d.stop_lim = fr_stop_lim;
            d.hold_v   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.sh       <= '1;
            q.bit_lim  <= TIM_W'(1);
            q.stop_lim <= TIM_W'(1);
        end else begin
            q <= d;
        end
    end

    assign txd      = !brk && ((q.st != ST_DATA) || q.sh[0]);
    assign tx_rdy   = !q.hold_v;
    assign tx_empty = !q.hold_v && !frame_active;

endmodule

// File: rtl/atx_checker.sv
module atx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic brk,
    input logic wr_stb,
    input logic tx_rdy,
    input logic tx_empty,
    input logic txd,
    input logic busy
);

    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_rdy) |=> !tx_rdy);

    p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en));

    p_empty_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    p_idle_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk) |-> txd);

endmodule

bind async_tx_framer atx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .brk     (brk),
    .wr_stb  (wr_stb),
    .tx_rdy  (tx_rdy),
    .tx_empty(tx_empty),
    .txd     (txd),
    .busy    (frame_active)
);

// File: tb/tb_async_tx_framer.sv
module tb_async_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] len_code = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic [1:0] stop_code = 2'b01;
    logic [1:0] fac_code = 2'b01;
    logic       tx_en = 1'b1;
    logic       brk = 1'b0;
    logic       bclk_en = 1'b1;
    logic       txd, tx_rdy, tx_empty;

    int total = 0;
    int bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    async_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .len_code(len_code), .par_en(par_en), .par_even(par_even),
        .stop_code(stop_code), .fac_code(fac_code), .tx_en(tx_en),
        .brk(brk), .bclk_en(bclk_en), .txd(txd), .tx_rdy(tx_rdy),
        .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input logic [1:0] f);
        if (f == 2'b10) return 16;
        if (f == 2'b11) return 64;
        return 1;
    endfunction

    function automatic int stop_of(input logic [1:0] s, input int lim);
        if (s == 2'b11) return 2 * lim;
        if (s == 2'b10) return (lim == 1) ? 2 : (3 * lim) / 2;
        return lim;
    endfunction

    task automatic write(input logic [7:0] dv);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = dv;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Compares txd every cycle with the frame expected for dv (R3 R4 R5 R6).
    task automatic frame_check(input logic [7:0] dv, input bit follow);
        int lim, len, nb, sc, mism, first_k, first_v;
        logic [11:0] bits;
        lim = lim_of(fac_code);
        len = 5 + int'(len_code);
        nb  = 1 + len + int'(par_en);
        sc  = stop_of(stop_code, lim);
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < len; i++) bits[i+1] = dv[i];
        if (par_en) begin
            int ones;
            ones = 0;
            for (int i = 0; i < len; i++) ones += int'(dv[i]);
            bits[len+1] = par_even ? ((ones % 2) == 1) : ((ones % 2) == 0);
        end
        mism = 0; first_k = -1; first_v = 0;
        for (int k = 0; k < nb * lim + sc; k++) begin
            logic e;
            @(negedge clk);
            e = (k < nb * lim) ? bits[k / lim] : 1'b1;
            if (txd !== e) begin
                if (first_k < 0) begin first_k = k; first_v = int'(e); end
                mism++;
            end
        end
        chk(mism == 0, "R3 R4 R5 R6 frame waveform (actual=first bad cycle)", first_k, first_v);
        if (!follow) begin
            @(negedge clk);
            chk(tx_empty === 1'b1 && txd === 1'b1, "R9 R12 empty and mark after stop",
                int'({tx_empty, txd}), 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] dv;
        int mism;
        dv = 8'h3C;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1, "R1 in reset",
            int'({txd, tx_rdy, tx_empty}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1, "R1 after reset",
            int'({txd, tx_rdy, tx_empty}), 7);

        // Sweep: x1 and x16 factors (codes 00,01,10), all stop codes, lengths, parity modes
        for (int f = 0; f < 3; f++)
            for (int s = 0; s < 4; s++)
                for (int l = 0; l < 4; l++)
                    for (int p = 0; p < 3; p++) begin
                        @(negedge clk);
                        fac_code  = 2'(f);
                        stop_code = 2'(s);
                        len_code  = 2'(l);
                        par_en    = (p != 0);
                        par_even  = (p == 2);
                        dv = dv * 8'd37 + 8'd11;
                        write(dv);
                        chk(tx_rdy === 1'b0, "R2 buffer filled", int'(tx_rdy), 0);
                        frame_check(dv, 1'b0);
                    end

        // x64 factor with each stop code (R5 R6)
        fac_code = 2'b11; len_code = 2'b11; par_en = 1'b1; par_even = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            stop_code = 2'(s);
            dv = 8'hC3 ^ 8'(s);
            write(dv);
            frame_check(dv, 1'b0);
        end

        // R7 R2: no start while disabled; write while full ignored
        fac_code = 2'b01; stop_code = 2'b01; len_code = 2'b11; par_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b0;
        write(8'h96);
        mism = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_rdy !== 1'b0 || tx_empty !== 1'b0) mism++;
        end
        chk(mism == 0, "R7 held while tx_en low", mism, 0);
        write(8'h5F);
        chk(tx_rdy === 1'b0, "R2 still full after ignored write", int'(tx_rdy), 0);
        tx_en = 1'b1;
        frame_check(8'h96, 1'b0);

        // R7 clearing tx_en mid-frame lets it finish
        fac_code = 2'b10; len_code = 2'b00; stop_code = 2'b01;
        @(negedge clk);
        write(8'hE7);
        fork
            frame_check(8'hE7, 1'b0);
            begin
                repeat (10) @(negedge clk);
                tx_en = 1'b0;
            end
        join
        tx_en = 1'b1;

        // R10 back-to-back frames, no gap
        fac_code = 2'b01; len_code = 2'b11; par_en = 1'b1; par_even = 1'b1; stop_code = 2'b11;
        @(negedge clk);
        write(8'hA1);
        fork
            frame_check(8'hA1, 1'b1);
            begin
                repeat (2) @(negedge clk);
                chk(tx_rdy === 1'b1, "R2 buffer free after load", int'(tx_rdy), 1);
                write(8'h4E);
            end
        join
        frame_check(8'h4E, 1'b0);
        chk(1'b1, "R10 second frame followed stop directly", 0, 0);

        // R8 break
        par_en = 1'b0; stop_code = 2'b01;
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R8 break at idle", int'(txd), 0);
        write(8'hFF);
        mism = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (txd !== 1'b0) mism++;
        end
        chk(mism == 0, "R8 break over frame", mism, 0);
        brk = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R8 R12 line after break",
            int'({txd, tx_empty}), 3);

        // R11 stalled bit clock
        write(8'hA5);
        bclk_en = 1'b0;
        mism = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (txd !== 1'b0) mism++;
        end
        chk(mism == 0, "R11 start bit held while bclk_en low", mism, 0);
        bclk_en = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R11 resume bit0", int'(txd), 1);
        @(negedge clk);
        chk(txd === 1'b0, "R11 resume bit1", int'(txd), 0);
        repeat (20) @(negedge clk);
        chk(tx_empty === 1'b1 && txd === 1'b1, "R9 idle after stalled frame",
            int'({tx_empty, txd}), 3);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule